// File: doc/BRIEF.md
# Sector-Buffered Block Storage Front End

This block is the register-level front end of a block-storage controller. It sits in a 1 MiB window on a word-wide register bus. The low part of the window holds four registers: control and status, sector count, starting sector number, and a read-only disk capacity. The upper half of the window is a 4096-byte sector buffer, which holds up to eight sectors of 512 bytes. The bus sees the buffer as 32-bit words, and the buffer repeats across the whole upper half.

Software writes the sector number and the sector count, then sets the start command bit. The direction bit in the same control word picks the transfer direction. The controller then runs a sector-transfer handshake with the disk side and moves bytes one at a time, always starting at buffer offset 0. The disk side reports success or failure, and the front end then records completion and the error status. An interrupt is raised while completion is pending and the interrupt is enabled.

Control is a four-state machine:
- BOOT waits for the disk side to report that it is initialised (transition *boot-done*).
- IDLE accepts commands. A start with a count of zero completes at once (*empty-start*). A start with a count of one or more enters STREAM (*launch*).
- STREAM moves one byte per handshake beat. After the last byte it goes to DRAIN (*last-beat*).
- From STREAM or DRAIN, a done report returns to IDLE (*completion*) and a fail report returns to IDLE with the error flag set (*abort*).

Top module: `sector_buf_ctrl`

## Requirements
- R1: After reset every register reads 0, including the ready flag at control bit 5. A start command is ignored until `dsk_init_done` is seen. From then on, control bit 5 reads 1.
- R2: The control word (byte offset 0x0) carries these fields. Bit 31 mirrors `dsk_dmarq`. Bit 4 is completion and bit 1 is interrupt enable; both are written and read back by software. Bit 3 is error (read-only) and bit 2 is direction. Bit 0 is start and always reads 0. All other bits read 0.
- R3: The sector count register (offset 0x4, bits 3..0) is written with any value and stores that value clamped to at most 8. The sector number register (offset 0x8) holds 32 bits. The capacity register (offset 0xC) always shows `dsk_capacity`, and writes to it have no effect.
- R4: While a transfer is in progress, bus writes are ignored for the direction bit, the sector number, the sector count and the buffer words.
- R5: With direction 0, the n-th byte received from the disk is stored at buffer byte n. Byte n lies in word n/4, in bits 31-8*(n%4) down to 24-8*(n%4) (big-endian).
- R6: With direction 1, exactly count*512 bytes are presented on `dsk_wbyte` with `dsk_wvalid`, in buffer byte order starting at offset 0. A byte moves when `dsk_wvalid` and `dsk_wready` are both high.
- R7: A done report sets completion and clears error. A fail report sets both completion and error and ends the transfer at once. Buffer bytes not yet received stay unchanged.
- R8: A start with a sector count of 0 sets completion and clears error at the same clock edge, and `dsk_req` is never raised.
- R9: `irq` is high exactly while completion and interrupt enable are both set. Writing 0 to completion drops it.
- R10: If a transfer ends in the same cycle as a software write of 0 to completion, completion ends up set.
- R11: The buffer word at byte offset 0x80000 + 4*w repeats every 4096 bytes up to 0xFFFFC. Register-half offsets from 0x10 to 0x7FFFC read 0.
- R12: `dsk_req` rises in the cycle after a launch and stays high until completion or abort. For that whole time, `dsk_write`, `dsk_lba` and `dsk_count` hold the direction, sector number and count of the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 18 | Word address in the window (byte address bits 19..2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read access |
| irq | output | 1 | Interrupt request |
| dsk_init_done | input | 1 | Disk side has finished initialisation |
| dsk_dmarq | input | 1 | Raw status flag reflected in control bit 31 |
| dsk_capacity | input | 32 | Total sectors on the disk |
| dsk_req | output | 1 | Transfer request active |
| dsk_write | output | 1 | 1 = buffer to disk |
| dsk_lba | output | 32 | First sector of the transfer |
| dsk_count | output | 4 | Sectors in the transfer |
| dsk_wbyte | output | 8 | Byte towards the disk |
| dsk_wvalid | output | 1 | `dsk_wbyte` valid |
| dsk_wready | input | 1 | Disk accepts the byte |
| dsk_rbyte | input | 8 | Byte from the disk |
| dsk_rvalid | input | 1 | `dsk_rbyte` valid |
| dsk_done | input | 1 | Transfer finished successfully |
| dsk_fail | input | 1 | Transfer failed |

## Verification
The completion event from the disk side and a software write to the control word can land on the same clock edge. The controller must then let completion win over a software clear of the completion bit, while still applying the interrupt-enable field from the same write. The bench forces this case: it drives `dsk_done` high on the very cycle it presents a control write of "completion 0, enable 1" during the DRAIN state. It then reads back completion = 1 with the interrupt raised. Register writes made during a stalled transfer are judged the same way, by reading the registers back after the transfer ends.

// File: rtl/blkfe_pkg.sv
package blkfe_pkg;

    typedef enum logic [1:0] {
        ENG_BOOT   = 2'd0,
        ENG_IDLE   = 2'd1,
        ENG_STREAM = 2'd2,
        ENG_DRAIN  = 2'd3
    } eng_state_e;

    // register select (byte offset bits 3..2)
    localparam logic [1:0] RSEL_CTRL  = 2'd0;
    localparam logic [1:0] RSEL_COUNT = 2'd1;
    localparam logic [1:0] RSEL_LBA   = 2'd2;
    localparam logic [1:0] RSEL_CAP   = 2'd3;

    // control word bit positions
    localparam int CB_GO    = 0;
    localparam int CB_IEN   = 1;
    localparam int CB_DIR   = 2;
    localparam int CB_ERR   = 3;
    localparam int CB_FIN   = 4;
    localparam int CB_RDY   = 5;
    localparam int CB_DMARQ = 31;

endpackage

// File: rtl/blkfe_buffer.sv
module blkfe_buffer #(
    parameter int BUF_BYTES = 4096,
    localparam int WORDS    = BUF_BYTES / 4,
    localparam int WIDX_W   = $clog2(WORDS),
    localparam int PTR_W    = $clog2(BUF_BYTES)
) (
    input  logic              clk,
    input  logic              bus_we,
    input  logic [WIDX_W-1:0] bus_idx,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rword,
    input  logic              fill_en,
    input  logic [PTR_W-1:0]  byte_ptr,
    input  logic [7:0]        fill_byte,
    output logic [7:0]        drain_byte
);

    logic [31:0] mem [WORDS];
    logic [4:0]  lane_sh;
    logic [31:0] ptr_word;

    // big-endian lane: byte 0 of a word sits in bits 31..24
    assign lane_sh    = {~byte_ptr[1:0], 3'b000};
    assign ptr_word   = mem[byte_ptr[PTR_W-1:2]];
    assign drain_byte = ptr_word[lane_sh +: 8];
    assign bus_rword  = mem[bus_idx];

    always_ff @(posedge clk) begin
        if (bus_we) begin
            mem[bus_idx] <= bus_wdata;
        end else if (fill_en) begin
            mem[byte_ptr[PTR_W-1:2]][lane_sh +: 8] <= fill_byte;
        end
    end

    always_ff @(posedge clk) begin
        AST_SINGLE_WRITER: assert (!(bus_we && fill_en)); // R4
    end

endmodule

// File: rtl/blkfe_engine.sv
module blkfe_engine
    import blkfe_pkg::*;
#(
    parameter int BUF_BYTES  = 4096,
    parameter int SECT_BYTES = 512,
    parameter int CNT_W      = 4,
    localparam int PTR_W     = $clog2(BUF_BYTES),
    localparam int SPAN_W    = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_done,
    input  logic             start,
    input  logic             dir_wr,
    input  logic [CNT_W-1:0] sect_cnt,
    input  logic             dsk_rvalid,
    input  logic             dsk_wready,
    input  logic             dsk_done,
    input  logic             dsk_fail,
    output logic             idle,
    output logic             busy,
    output logic             finish,
    output logic             finish_err,
    output logic [PTR_W-1:0] byte_ptr,
    output logic             fill_en,
    output logic             dsk_req,
    output logic             dsk_wvalid
);

    eng_state_e       state_q, state_d;
    logic [PTR_W-1:0] ptr_q, last_q;
    logic             launch, beat;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENG_BOOT;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d    = state_q;
        finish     = 1'b0;
        finish_err = 1'b0;
        launch     = 1'b0;
        beat       = 1'b0;
        unique case (state_q)
            ENG_BOOT: begin
                if (init_done) state_d = ENG_IDLE;              // boot-done
            end
            ENG_IDLE: begin
                if (start) begin
                    if (sect_cnt == '0) begin
                        finish = 1'b1;                          // empty-start
                    end else begin
                        launch  = 1'b1;                         // launch
                        state_d = ENG_STREAM;
                    end
                end
            end
            ENG_STREAM: begin
                if (dsk_fail) begin                             // abort
                    finish     = 1'b1;
                    finish_err = 1'b1;
                    state_d    = ENG_IDLE;
                end else if (dsk_done) begin                    // completion
                    finish  = 1'b1;
                    state_d = ENG_IDLE;
                end else begin
                    beat = dir_wr ? dsk_wready : dsk_rvalid;
                    if (beat && ptr_q == last_q) state_d = ENG_DRAIN;  // last-beat
                end
            end
            ENG_DRAIN: begin
                if (dsk_fail) begin                             // abort
                    finish     = 1'b1;
                    finish_err = 1'b1;
                    state_d    = ENG_IDLE;
                end else if (dsk_done) begin                    // completion
                    finish  = 1'b1;
                    state_d = ENG_IDLE;
                end
            end
            default: state_d = ENG_BOOT;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        idle       = (state_q == ENG_IDLE);
        busy       = (state_q == ENG_STREAM) || (state_q == ENG_DRAIN);
        dsk_req    = busy;
        dsk_wvalid = (state_q == ENG_STREAM) && dir_wr;
        fill_en    = beat && !dir_wr;
        byte_ptr   = ptr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            last_q <= '0;
        end else if (launch) begin
            ptr_q  <= '0;
            last_q <= PTR_W'(SPAN_W'(sect_cnt) * SPAN_W'(SECT_BYTES) - SPAN_W'(1));
        end else if (beat) begin
            ptr_q  <= ptr_q + 1'b1;
        end
    end

    AST_PTR_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_STREAM) |-> (ptr_q <= last_q)); // R6
    AST_NO_REQ_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_IDLE && start && sect_cnt == '0) |=> !dsk_req); // R8
    AST_REQ_AFTER_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_IDLE && start && sect_cnt != '0) |=> dsk_req); // R12

endmodule

// File: rtl/sector_buf_ctrl.sv
module sector_buf_ctrl
    import blkfe_pkg::*;
#(
    parameter int WIN_AW     = 20,
    parameter int BUF_BYTES  = 4096,
    parameter int SECT_BYTES = 512,
    localparam int MAX_SECT  = BUF_BYTES / SECT_BYTES,
    localparam int CNT_W     = $clog2(MAX_SECT + 1),
    localparam int PTR_W     = $clog2(BUF_BYTES),
    localparam int BIDX_W    = PTR_W - 2,
    localparam int BA_W      = WIN_AW - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [BA_W-1:0]  bus_waddr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             irq,
    input  logic             dsk_init_done,
    input  logic             dsk_dmarq,
    input  logic [31:0]      dsk_capacity,
    output logic             dsk_req,
    output logic             dsk_write,
    output logic [31:0]      dsk_lba,
    output logic [CNT_W-1:0] dsk_count,
    output logic [7:0]       dsk_wbyte,
    output logic             dsk_wvalid,
    input  logic             dsk_wready,
    input  logic [7:0]       dsk_rbyte,
    input  logic             dsk_rvalid,
    input  logic             dsk_done,
    input  logic             dsk_fail
);

    logic             fin_q, ien_q, err_q, dir_q;
    logic [31:0]      lba_q;
    logic [CNT_W-1:0] cnt_q;
    logic             in_buf, in_regs;
    logic [1:0]       rsel;
    logic             wr_ctrl, wr_count, wr_lba, buf_we, start;
    logic             eng_idle, eng_busy, eng_finish, eng_finish_err, fill_en;
    logic [PTR_W-1:0] byte_ptr;
    logic [31:0]      buf_rword, ctrl_word, rd_mux;

    // window decode: upper half is the mirrored buffer
    assign in_buf   = bus_waddr[BA_W-1];
    assign in_regs  = !in_buf && (bus_waddr[BA_W-2:2] == '0);
    assign rsel     = bus_waddr[1:0];
    assign wr_ctrl  = bus_sel && bus_we && in_regs && (rsel == RSEL_CTRL);
    assign wr_count = bus_sel && bus_we && in_regs && (rsel == RSEL_COUNT) && !eng_busy;
    assign wr_lba   = bus_sel && bus_we && in_regs && (rsel == RSEL_LBA) && !eng_busy;
    assign buf_we   = bus_sel && bus_we && in_buf && !eng_busy;
    assign start    = wr_ctrl && bus_wdata[CB_GO] && eng_idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fin_q <= 1'b0;
            ien_q <= 1'b0;
            err_q <= 1'b0;
            dir_q <= 1'b0;
            lba_q <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_ctrl) begin
                fin_q <= bus_wdata[CB_FIN];
                ien_q <= bus_wdata[CB_IEN];
                if (!eng_busy) dir_q <= bus_wdata[CB_DIR];
            end
            if (eng_finish) begin          // completion overrides a software clear
                fin_q <= 1'b1;
                err_q <= eng_finish_err;
            end
            if (wr_count) begin
                cnt_q <= (bus_wdata > 32'(MAX_SECT)) ? CNT_W'(MAX_SECT)
                                                     : bus_wdata[CNT_W-1:0];
            end
            if (wr_lba) lba_q <= bus_wdata;
        end
    end

    always_comb begin
        ctrl_word           = '0;
        ctrl_word[CB_DMARQ] = dsk_dmarq;
        ctrl_word[CB_RDY]   = eng_idle || eng_busy;
        ctrl_word[CB_FIN]   = fin_q;
        ctrl_word[CB_ERR]   = err_q;
        ctrl_word[CB_DIR]   = dir_q;
        ctrl_word[CB_IEN]   = ien_q;
    end

    always_comb begin
        rd_mux = '0;
        if (in_buf) begin
            rd_mux = buf_rword;
        end else if (in_regs) begin
            unique case (rsel)
                RSEL_CTRL:  rd_mux = ctrl_word;
                RSEL_COUNT: rd_mux = 32'(cnt_q);
                RSEL_LBA:   rd_mux = lba_q;
                RSEL_CAP:   rd_mux = dsk_capacity;
                default:    rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  bus_rdata <= '0;
        else if (bus_sel && !bus_we) bus_rdata <= rd_mux;
    end

    assign irq       = fin_q && ien_q;
    assign dsk_write = dir_q;
    assign dsk_lba   = lba_q;
    assign dsk_count = cnt_q;

    blkfe_engine #(
        .BUF_BYTES (BUF_BYTES),
        .SECT_BYTES(SECT_BYTES),
        .CNT_W     (CNT_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_done (dsk_init_done),
        .start     (start),
        .dir_wr    (dir_q),
        .sect_cnt  (cnt_q),
        .dsk_rvalid(dsk_rvalid),
        .dsk_wready(dsk_wready),
        .dsk_done  (dsk_done),
        .dsk_fail  (dsk_fail),
        .idle      (eng_idle),
        .busy      (eng_busy),
        .finish    (eng_finish),
        .finish_err(eng_finish_err),
        .byte_ptr  (byte_ptr),
        .fill_en   (fill_en),
        .dsk_req   (dsk_req),
        .dsk_wvalid(dsk_wvalid)
    );

    blkfe_buffer #(
        .BUF_BYTES(BUF_BYTES)
    ) u_buffer (
        .clk       (clk),
        .bus_we    (buf_we),
        .bus_idx   (bus_waddr[BIDX_W-1:0]),
        .bus_wdata (bus_wdata),
        .bus_rword (buf_rword),
        .fill_en   (fill_en),
        .byte_ptr  (byte_ptr),
        .fill_byte (dsk_rbyte),
        .drain_byte(dsk_wbyte)
    );

    AST_LOCK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |=> ($stable(dir_q) && $stable(lba_q) && $stable(cnt_q))); // R4
    AST_FIN_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        eng_finish |=> fin_q); // R10
    AST_ERR_FOLLOWS_END: assert property (@(posedge clk) disable iff (!rst_n)
        eng_finish |=> (err_q == $past(eng_finish_err))); // R7
    AST_COUNT_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_SECT)); // R3

endmodule

// File: tb/sector_buf_ctrl_tb.sv
module sector_buf_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_we;
    logic [17:0] bus_waddr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq;
    logic        dsk_init_done, dsk_dmarq;
    logic [31:0] dsk_capacity;
    logic        dsk_req, dsk_write;
    logic [31:0] dsk_lba;
    logic [3:0]  dsk_count;
    logic [7:0]  dsk_wbyte, dsk_rbyte;
    logic        dsk_wvalid, dsk_wready, dsk_rvalid, dsk_done, dsk_fail;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_buf [4096];

    always #4 clk = ~clk;   // 125 MHz

    sector_buf_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .dsk_init_done(dsk_init_done), .dsk_dmarq(dsk_dmarq),
        .dsk_capacity(dsk_capacity), .dsk_req(dsk_req), .dsk_write(dsk_write),
        .dsk_lba(dsk_lba), .dsk_count(dsk_count), .dsk_wbyte(dsk_wbyte),
        .dsk_wvalid(dsk_wvalid), .dsk_wready(dsk_wready), .dsk_rbyte(dsk_rbyte),
        .dsk_rvalid(dsk_rvalid), .dsk_done(dsk_done), .dsk_fail(dsk_fail)
    );

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37 + i * 5 + (i >> 7)) & 255);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_waddr = a[19:2]; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [19:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_waddr = a[19:2];
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input logic [19:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        bus_rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic chk_buf(input int nw, input string tag);
        for (int w = 0; w < nw; w++) begin
            rd_chk(20'h80000 + 20'(w * 4),
                   {exp_buf[4*w], exp_buf[4*w+1], exp_buf[4*w+2], exp_buf[4*w+3]}, tag);
        end
    endtask

    task automatic feed(input int seed, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dsk_rvalid = 1'b1;
            dsk_rbyte  = pat(seed, i);
            exp_buf[i] = pat(seed, i);
        end
        @(negedge clk);
        dsk_rvalid = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); dsk_done = 1'b1;
        @(negedge clk); dsk_done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual run still active, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] w32;
        int          j;
        rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_waddr = '0; bus_wdata = '0;
        dsk_init_done = 1'b0; dsk_dmarq = 1'b0; dsk_capacity = 32'h0012_3456;
        dsk_wready = 1'b0; dsk_rbyte = '0; dsk_rvalid = 1'b0; dsk_done = 1'b0; dsk_fail = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, start ignored before init
        rd_chk(20'h0, 32'h0, "R1 ctrl after reset");
        bus_wr(20'h0, 32'h1);
        rd_chk(20'h0, 32'h0, "R1 start before init ignored");
        chk("R1 no request before init", 32'(dsk_req), 32'h0);
        @(negedge clk); dsk_init_done = 1'b1;
        repeat (2) @(negedge clk);
        rd_chk(20'h0, 32'h20, "R1 ready bit after init");

        // R2: control layout
        dsk_dmarq = 1'b1;
        rd_chk(20'h0, 32'h8000_0020, "R2 dmarq mirror");
        dsk_dmarq = 1'b0;
        bus_wr(20'h0, 32'hFFFF_FFD2);
        rd_chk(20'h0, 32'h32, "R2 fin/ien writable, others zero");
        // R9: interrupt
        chk("R9 irq with fin and ien", 32'(irq), 32'h1);
        bus_wr(20'h0, 32'h2);
        chk("R9 irq after fin clear", 32'(irq), 32'h0);
        rd_chk(20'h0, 32'h22, "R9 ctrl after fin clear");
        bus_wr(20'h0, 32'h10);
        chk("R9 irq with fin only", 32'(irq), 32'h0);
        bus_wr(20'h0, 32'h0);

        // R3: count clamp, lba, capacity
        bus_wr(20'h4, 32'd13);
        rd_chk(20'h4, 32'd8, "R3 count clamp 13");
        bus_wr(20'h4, 32'hFFFF_FFFF);
        rd_chk(20'h4, 32'd8, "R3 count clamp max");
        for (int c = 0; c <= 8; c++) begin
            bus_wr(20'h4, 32'(c));
            rd_chk(20'h4, 32'(c), "R3 count in range");
        end
        bus_wr(20'h8, 32'hDEAD_BEEF);
        rd_chk(20'h8, 32'hDEAD_BEEF, "R3 lba readback");
        bus_wr(20'hC, 32'h0000_FFFF);
        rd_chk(20'hC, 32'h0012_3456, "R3 capacity read-only");

        // R11: register hole reads zero
        rd_chk(20'h10, 32'h0, "R11 hole 0x10");
        rd_chk(20'h7FFFC, 32'h0, "R11 hole top");

        // preload buffer through the bus (R11 word view)
        for (int w = 0; w < 1024; w++) begin
            w32 = {16'(w), ~16'(w)} ^ 32'h5A00_00A5;
            bus_wr(20'h80000 + 20'(w * 4), w32);
            {exp_buf[4*w], exp_buf[4*w+1], exp_buf[4*w+2], exp_buf[4*w+3]} = w32;
        end
        chk_buf(1024, "R11 buffer preload");

        // R8: empty start
        bus_wr(20'h4, 32'd0);
        bus_wr(20'h0, 32'h1);
        chk("R8 no request on empty", 32'(dsk_req), 32'h0);
        rd_chk(20'h0, 32'h30, "R8 fin set err clear");
        bus_wr(20'h0, 32'h0);

        // R5/R12/R7: read transfer, 3 sectors
        bus_wr(20'h8, 32'h100);
        bus_wr(20'h4, 32'd3);
        bus_wr(20'h0, 32'h1);
        chk("R12 req after launch", 32'(dsk_req), 32'h1);
        chk("R12 direction", 32'(dsk_write), 32'h0);
        chk("R12 lba", dsk_lba, 32'h100);
        chk("R12 count", 32'(dsk_count), 32'd3);
        feed(32'h100, 1536);
        chk("R12 req held in drain", 32'(dsk_req), 32'h1);
        rd_chk(20'h0, 32'h20, "R7 fin clear before done");
        pulse_done();
        chk("R12 req drops", 32'(dsk_req), 32'h0);
        rd_chk(20'h0, 32'h30, "R7 done sets fin clears err");
        chk_buf(1024, "R5 big-endian fill");

        // R11: mirror
        for (int k = 1; k < 128; k += 9) begin
            for (int w = 0; w < 1024; w += 97) begin
                rd_chk(20'h80000 + 20'(k * 4096 + w * 4),
                       {exp_buf[4*w], exp_buf[4*w+1], exp_buf[4*w+2], exp_buf[4*w+3]},
                       "R11 mirror");
            end
        end

        // R10: completion on the same edge as a software fin clear
        bus_wr(20'h0, 32'h0);
        bus_wr(20'h8, 32'h7);
        bus_wr(20'h4, 32'd1);
        bus_wr(20'h0, 32'h3);
        feed(7, 512);
        dsk_done = 1'b1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_waddr = '0; bus_wdata = 32'h2;
        @(negedge clk);
        dsk_done = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        rd_chk(20'h0, 32'h32, "R10 completion beats fin clear");
        chk("R10 irq raised", 32'(irq), 32'h1);
        chk_buf(128, "R5 single sector fill");
        bus_wr(20'h0, 32'h0);

        // R6/R4: write transfer, 2 sectors, with writes attempted while busy
        for (int w = 0; w < 256; w++) begin
            w32 = 32'h1357_9BDF * 32'(w + 3);
            bus_wr(20'h80000 + 20'(w * 4), w32);
            {exp_buf[4*w], exp_buf[4*w+1], exp_buf[4*w+2], exp_buf[4*w+3]} = w32;
        end
        bus_wr(20'h8, 32'h55);
        bus_wr(20'h4, 32'd2);
        bus_wr(20'h0, 32'h5);
        bus_wr(20'h4, 32'd7);
        bus_wr(20'h8, 32'h99);
        bus_wr(20'h0, 32'h0);
        bus_wr(20'h80028, 32'hAAAA_5555);
        chk("R4 direction locked", 32'(dsk_write), 32'h1);
        chk("R4 lba locked", dsk_lba, 32'h55);
        chk("R4 count locked", 32'(dsk_count), 32'd2);
        @(negedge clk);
        dsk_wready = 1'b1;
        j = 0;
        while (j < 1024) begin
            if (dsk_wvalid) begin
                chk("R6 outgoing byte", 32'(dsk_wbyte), 32'(exp_buf[j]));
                j++;
            end
            @(negedge clk);
        end
        dsk_wready = 1'b0;
        @(negedge clk);
        chk("R6 no extra bytes", 32'(dsk_wvalid), 32'h0);
        pulse_done();
        rd_chk(20'h0, 32'h34, "R4 direction kept, fin set");
        rd_chk(20'h4, 32'd2, "R4 count unchanged");
        rd_chk(20'h8, 32'h55, "R4 lba unchanged");
        chk_buf(256, "R4 buffer write ignored while busy");

        // R7: abort mid-transfer
        bus_wr(20'h8, 32'h200);
        bus_wr(20'h4, 32'd4);
        bus_wr(20'h0, 32'h1);
        feed(32'h200, 100);
        @(negedge clk); dsk_fail = 1'b1;
        @(negedge clk); dsk_fail = 1'b0;
        chk("R7 req drops on fail", 32'(dsk_req), 32'h0);
        rd_chk(20'h0, 32'h38, "R7 fail sets fin and err");
        chk_buf(1024, "R7 remaining bytes untouched");

        // R7/R8: a later successful (empty) transfer clears err
        bus_wr(20'h4, 32'd0);
        bus_wr(20'h0, 32'h1);
        rd_chk(20'h0, 32'h30, "R7 err cleared on success");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule